// File: doc/BRIEF.md
# Shared Pin Mode Controller

This block decides, pin by pin, whether a small group of shared device pins act as software-controlled general-purpose lines or hand over to bus-interface functions. A single mode input selects between card-bus operation and ISA operation. In ISA operation every shared pin becomes an input, and its level is passed on to the ISA logic behind it. In card-bus operation each user pin is either an input or an output. The choice comes from its own enable bit, and an output takes its value from its own bit of a user data register.

One further pin carries a status-change indication. A function bit selects how it is driven. With the function bit set, a card wakeup status bit reaches the pin only while an unmask bit is set. The unmask bit clears itself whenever the wakeup status is cleared, so software must set it again for every new wakeup. With the function bit clear, the pin is driven with the inverse of the unmask bit.

Readback of the user data register and of the unmask bit does not return the stored value. It returns the live, synchronised level of the pins.

Top module: `mfpin_ctrl`

## Requirements
- R1: After reset, all user pin output enables are 0. The enable register reads 0 and the control register reads 0. In card-bus mode the status pin is driven to 1.
- R2: While `isa_mode` is 1, every user pin output enable and the status pin output enable are 0, whatever the register contents. `isa_user_sig` and `isa_stat_sig` follow the raw pin inputs. Outside ISA mode both are 0.
- R3: While `isa_mode` is 0, user pin i has output enable equal to enable bit i. When enabled, the pin drives user data bit i. A disabled pin drives 0.
- R4: Reading address 1 returns the user pin input levels after two clock edges of synchronisation, in every pin configuration. The stored user data is not returned.
- R5: In card-bus mode, with function bit 1 and unmask bit 0, the status pin is driven to 0 whatever the wakeup status.
- R6: In card-bus mode, with function bit 1 and unmask bit 1, the status pin level equals the wakeup status bit.
- R7: A one-cycle `wake_evt` sets the wakeup status at the next edge. A write to address 2 with bit 1 at 0 clears it. When a set and a clear fall in the same cycle, the set wins. Writing 1 to bit 1 has no effect.
- R8: Any write that clears the wakeup status also clears the unmask bit at the same edge. A following wakeup stays hidden until the unmask bit is set again.
- R9: In card-bus mode with function bit 0, the status pin is driven with the inverse of the unmask bit.
- R10: Reading address 3 returns in bit 0 the inverse of the synchronised status pin input, with the upper bits 0.
- R11: A write updates its register at the clock edge where `wr_en` is 1. The address map is: 0 = enables, 1 = user data, 2 = control (bit 0 function, bit 1 wakeup), 3 = unmask (bit 0). Reading address 2 returns {wakeup, function} in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| isa_mode | input | 1 | 1 selects ISA operation, 0 selects card-bus operation |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | NUM_USER | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | NUM_USER | Read data, combinational from `rd_addr` |
| wake_evt | input | 1 | One-cycle wakeup event |
| user_pin_in | input | NUM_USER | User pin input levels |
| user_pin_oe | output | NUM_USER | User pin output enables |
| user_pin_out | output | NUM_USER | User pin output levels |
| stat_pin_in | input | 1 | Status pin input level |
| stat_pin_oe | output | 1 | Status pin output enable |
| stat_pin_out | output | 1 | Status pin output level |
| isa_user_sig | output | NUM_USER | User pin levels passed to the ISA functions |
| isa_stat_sig | output | 1 | Status pin level passed to the ISA function |

## Verification
A wrong enable or data bit shows at `user_pin_oe` or `user_pin_out` at the first falling clock edge after the write. A stuck unmask or wakeup bit shows at `stat_pin_out` in the same cycle in which the function bit selects that path. A synchroniser that is too short or too long shows in the readback at addresses 1 and 3. The readback is checked both one edge and two edges after a pin change, so an off-by-one stage count is caught there. A missing self-clear of the unmask bit stays hidden until the next wakeup event. The bench therefore raises a wakeup after every clear and checks that the status pin stays low.

// File: rtl/mfpin_pkg.sv
package mfpin_pkg;

  typedef enum logic [1:0] {
    RA_ENABLE = 2'd0,
    RA_UDATA  = 2'd1,
    RA_CTRL   = 2'd2,
    RA_MASK   = 2'd3
  } reg_addr_e;

  localparam int CTRL_FN_BIT   = 0;
  localparam int CTRL_WAKE_BIT = 1;

  // level driven on the status pin in card-bus mode
  function automatic logic stat_level(input logic fn, input logic mask, input logic wake);
    return fn ? (mask & wake) : ~mask;
  endfunction

  // direction of one user pin
  function automatic logic user_dir(input logic isa, input logic en);
    return ~isa & en;
  endfunction

endpackage

// File: rtl/mfpin_sync.sv
module mfpin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d_in;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/mfpin_regs.sv
module mfpin_regs
  import mfpin_pkg::*;
#(
  parameter int NUM_USER = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [NUM_USER-1:0] wr_data,
  input  logic                wake_evt,
  output logic [NUM_USER-1:0] en_q,
  output logic [NUM_USER-1:0] udata_q,
  output logic                fn_q,
  output logic                wake_q,
  output logic                mask_q,
  output logic                wake_clr
);
  logic wr_en_reg, wr_ud_reg, wr_ctrl, wr_mask;

  assign wr_en_reg = wr_en && (wr_addr == RA_ENABLE);
  assign wr_ud_reg = wr_en && (wr_addr == RA_UDATA);
  assign wr_ctrl   = wr_en && (wr_addr == RA_CTRL);
  assign wr_mask   = wr_en && (wr_addr == RA_MASK);

  // a clear loses against a simultaneous wakeup event
  assign wake_clr = wr_ctrl && !wr_data[CTRL_WAKE_BIT] && !wake_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      udata_q <= '0;
      fn_q    <= 1'b0;
    end else begin
      if (wr_en_reg) en_q    <= wr_data;
      if (wr_ud_reg) udata_q <= wr_data;
      if (wr_ctrl)   fn_q    <= wr_data[CTRL_FN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wake_q <= 1'b0;
    else if (wake_evt) wake_q <= 1'b1;
    else if (wake_clr) wake_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= 1'b0;
    else if (wake_clr) mask_q <= 1'b0;
    else if (wr_mask)  mask_q <= wr_data[0];
  end
endmodule

// File: rtl/mfpin_user_drv.sv
module mfpin_user_drv
  import mfpin_pkg::*;
#(
  parameter int NUM_USER = 4
) (
  input  logic                isa_mode,
  input  logic [NUM_USER-1:0] en_q,
  input  logic [NUM_USER-1:0] udata_q,
  input  logic [NUM_USER-1:0] pin_in,
  output logic [NUM_USER-1:0] pin_oe,
  output logic [NUM_USER-1:0] pin_out,
  output logic [NUM_USER-1:0] isa_sig
);
  for (genvar i = 0; i < NUM_USER; i++) begin : g_pin
    assign pin_oe[i]  = user_dir(isa_mode, en_q[i]);
    assign pin_out[i] = pin_oe[i] & udata_q[i];
    assign isa_sig[i] = isa_mode & pin_in[i];
  end
endmodule

// File: rtl/mfpin_stat_drv.sv
module mfpin_stat_drv
  import mfpin_pkg::*;
(
  input  logic isa_mode,
  input  logic fn_q,
  input  logic mask_q,
  input  logic wake_q,
  input  logic pin_in,
  output logic pin_oe,
  output logic pin_out,
  output logic isa_sig
);
  assign pin_oe  = ~isa_mode;
  assign pin_out = isa_mode ? 1'b0 : stat_level(fn_q, mask_q, wake_q);
  assign isa_sig = isa_mode & pin_in;
endmodule

// File: rtl/mfpin_ctrl.sv
module mfpin_ctrl
  import mfpin_pkg::*;
#(
  parameter int NUM_USER    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                isa_mode,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [NUM_USER-1:0] wr_data,
  input  logic [1:0]          rd_addr,
  output logic [NUM_USER-1:0] rd_data,
  input  logic                wake_evt,
  input  logic [NUM_USER-1:0] user_pin_in,
  output logic [NUM_USER-1:0] user_pin_oe,
  output logic [NUM_USER-1:0] user_pin_out,
  input  logic                stat_pin_in,
  output logic                stat_pin_oe,
  output logic                stat_pin_out,
  output logic [NUM_USER-1:0] isa_user_sig,
  output logic                isa_stat_sig
);
  localparam int SYNC_W = NUM_USER + 1;

  logic [NUM_USER-1:0] en_q, udata_q;
  logic                fn_q, wake_q, mask_q, wake_clr;
  logic [SYNC_W-1:0]   pin_sync;
  logic [NUM_USER-1:0] user_sync;
  logic                stat_sync;

  mfpin_regs #(.NUM_USER(NUM_USER)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wake_evt(wake_evt), .en_q(en_q), .udata_q(udata_q),
    .fn_q(fn_q), .wake_q(wake_q), .mask_q(mask_q), .wake_clr(wake_clr)
  );

  mfpin_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({stat_pin_in, user_pin_in}), .q_out(pin_sync)
  );

  assign user_sync = pin_sync[NUM_USER-1:0];
  assign stat_sync = pin_sync[NUM_USER];

  mfpin_user_drv #(.NUM_USER(NUM_USER)) u_user (
    .isa_mode(isa_mode), .en_q(en_q), .udata_q(udata_q), .pin_in(user_pin_in),
    .pin_oe(user_pin_oe), .pin_out(user_pin_out), .isa_sig(isa_user_sig)
  );

  mfpin_stat_drv u_stat (
    .isa_mode(isa_mode), .fn_q(fn_q), .mask_q(mask_q), .wake_q(wake_q),
    .pin_in(stat_pin_in), .pin_oe(stat_pin_oe), .pin_out(stat_pin_out),
    .isa_sig(isa_stat_sig)
  );

  // readback: the data and unmask locations show live pin levels
  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      RA_ENABLE: rd_data = en_q;
      RA_UDATA:  rd_data = user_sync;
      RA_CTRL: begin
        rd_data[CTRL_FN_BIT]   = fn_q;
        rd_data[CTRL_WAKE_BIT] = wake_q;
      end
      default:   rd_data[0] = ~stat_sync;
    endcase
  end
endmodule

// File: rtl/mfpin_chk.sv
module mfpin_chk #(
  parameter int NUM_USER = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                isa_mode,
  input logic [1:0]          rd_addr,
  input logic [NUM_USER-1:0] rd_data,
  input logic [NUM_USER-1:0] user_pin_oe,
  input logic [NUM_USER-1:0] user_pin_out,
  input logic                stat_pin_oe,
  input logic                stat_pin_out,
  input logic                wake_evt,
  input logic                wake_clr,
  input logic                wake_q,
  input logic                mask_q,
  input logic                fn_q,
  input logic [NUM_USER-1:0] udata_q
);
  p_isa_all_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    isa_mode |-> (user_pin_oe == '0) && !stat_pin_oe);

  p_oe_matches_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!isa_mode && rd_addr == 2'd0) |-> (user_pin_oe == rd_data));

  p_out_from_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !isa_mode |-> ((user_pin_out & ~user_pin_oe) == '0) &&
                  ((user_pin_out & user_pin_oe) == (udata_q & user_pin_oe)));

  p_masked_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!isa_mode && fn_q && !mask_q) |-> !stat_pin_out);

  p_unmasked_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!isa_mode && fn_q && mask_q) |-> (stat_pin_out == wake_q));

  p_wake_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> wake_q);

  p_wake_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_clr |=> !wake_q);

  p_mask_autoclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_clr |=> !mask_q);

  p_inverse_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!isa_mode && !fn_q) |-> (stat_pin_out == !mask_q));
endmodule

bind mfpin_ctrl mfpin_chk #(.NUM_USER(NUM_USER)) u_chk (
  .clk(clk), .rst_n(rst_n), .isa_mode(isa_mode), .rd_addr(rd_addr),
  .rd_data(rd_data), .user_pin_oe(user_pin_oe), .user_pin_out(user_pin_out),
  .stat_pin_oe(stat_pin_oe), .stat_pin_out(stat_pin_out), .wake_evt(wake_evt),
  .wake_clr(wake_clr), .wake_q(wake_q), .mask_q(mask_q), .fn_q(fn_q),
  .udata_q(udata_q)
);

// File: tb/test_mfpin_ctrl.sv
module test_mfpin_ctrl;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         isa_mode = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [N-1:0] rd_data;
  logic         wake_evt = 1'b0;
  logic [N-1:0] user_pin_in = '0;
  logic [N-1:0] user_pin_oe, user_pin_out, isa_user_sig;
  logic         stat_pin_in = 1'b0;
  logic         stat_pin_oe, stat_pin_out, isa_stat_sig;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  mfpin_ctrl #(.NUM_USER(N), .SYNC_STAGES(2)) i_mfpin_ctrl (
    .clk(clk), .rst_n(rst_n), .isa_mode(isa_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wake_evt(wake_evt), .user_pin_in(user_pin_in), .user_pin_oe(user_pin_oe),
    .user_pin_out(user_pin_out), .stat_pin_in(stat_pin_in),
    .stat_pin_oe(stat_pin_oe), .stat_pin_out(stat_pin_out),
    .isa_user_sig(isa_user_sig), .isa_stat_sig(isa_stat_sig)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs change on the falling edge; results sampled one time unit later
  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [N-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wake_pulse(input logic with_clear);
    @(negedge clk);
    wake_evt = 1'b1;
    if (with_clear) begin
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = 4'b0001;
    end
    @(negedge clk);
    wake_evt = 1'b0; wr_en = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    chk("R1 user oe", user_pin_oe, '0);
    reg_rd(2'd0, d); chk("R1 enable reg", d, '0);
    reg_rd(2'd2, d); chk("R1 ctrl reg", d, '0);
    chk("R1 stat oe", stat_pin_oe, 1'b1);
    chk("R1 stat level", stat_pin_out, 1'b1);
  endtask

  task automatic t_user_dir();
    logic [N-1:0] d;
    reg_wr(2'd1, 4'b0011);
    chk("R11 data write hidden", user_pin_oe, '0);
    reg_wr(2'd0, 4'b0101);
    chk("R3 oe", user_pin_oe, 4'b0101);
    chk("R3 out", user_pin_out, 4'b0001);
    reg_rd(2'd0, d); chk("R11 enable readback", d, 4'b0101);
    reg_wr(2'd1, 4'b1100);
    chk("R3 out after data change", user_pin_out, 4'b0100);
  endtask

  task automatic t_readback();
    logic [N-1:0] d;
    @(negedge clk);
    user_pin_in = 4'b1010;
    ticks(1);
    reg_rd(2'd1, d); chk("R4 one edge late", d, 4'b0000);
    ticks(1);
    reg_rd(2'd1, d); chk("R4 two edges", d, 4'b1010);
    reg_rd(2'd0, d); chk("R4 enable untouched", d, 4'b0101);
  endtask

  task automatic t_status();
    logic [N-1:0] d;
    reg_wr(2'd2, 4'b0001);
    chk("R5 masked idle", stat_pin_out, 1'b0);
    wake_pulse(1'b0);
    reg_rd(2'd2, d); chk("R7 wake set", d, 4'b0011);
    chk("R5 masked with wake", stat_pin_out, 1'b0);
    reg_wr(2'd3, 4'b0001);
    chk("R6 unmasked wake", stat_pin_out, 1'b1);
    reg_wr(2'd2, 4'b0011);
    reg_rd(2'd2, d); chk("R7 write one no effect", d, 4'b0011);
    reg_wr(2'd2, 4'b0001);
    reg_rd(2'd2, d); chk("R7 wake cleared", d, 4'b0001);
    chk("R6 cleared wake low", stat_pin_out, 1'b0);
    wake_pulse(1'b0);
    chk("R8 rearm needed", stat_pin_out, 1'b0);
    reg_wr(2'd3, 4'b0001);
    chk("R8 rearmed", stat_pin_out, 1'b1);
    wake_pulse(1'b1);
    reg_rd(2'd2, d); chk("R7 set beats clear", d, 4'b0011);
    chk("R8 mask kept on set win", stat_pin_out, 1'b1);
  endtask

  task automatic t_stat_read();
    logic [N-1:0] d;
    @(negedge clk);
    stat_pin_in = 1'b1;
    ticks(2);
    reg_rd(2'd3, d); chk("R10 pin high", d, 4'b0000);
    @(negedge clk);
    stat_pin_in = 1'b0;
    ticks(2);
    reg_rd(2'd3, d); chk("R10 pin low", d, 4'b0001);
  endtask

  task automatic t_inverse();
    reg_wr(2'd2, 4'b0000);
    chk("R9 mask cleared drives 1", stat_pin_out, 1'b1);
    reg_wr(2'd3, 4'b0001);
    chk("R9 mask set drives 0", stat_pin_out, 1'b0);
  endtask

  task automatic t_isa();
    logic [N-1:0] d;
    reg_wr(2'd0, 4'b1111);
    @(negedge clk);
    isa_mode = 1'b1; user_pin_in = 4'b0110; stat_pin_in = 1'b1;
    #1;
    chk("R2 user oe", user_pin_oe, '0);
    chk("R2 stat oe", stat_pin_oe, 1'b0);
    chk("R2 isa user", isa_user_sig, 4'b0110);
    chk("R2 isa stat", isa_stat_sig, 1'b1);
    ticks(2);
    reg_rd(2'd1, d); chk("R4 readback in isa", d, 4'b0110);
    @(negedge clk);
    isa_mode = 1'b0;
    #1;
    chk("R2 isa sig off", isa_user_sig, '0);
    chk("R3 enables back", user_pin_oe, 4'b1111);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ticks(3);
    rst_n = 1'b1;
    ticks(1);
    t_reset();
    t_user_dir();
    t_readback();
    t_status();
    t_stat_read();
    t_inverse();
    t_isa();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule